// File: doc/BRIEF.md
# Reconfigurable Two-Input Logic Cell

This block is a single programmable logic cell with two signal inputs and one output. A small configuration word decides what it is: a two-input lookup table that can realise any Boolean function of its inputs, an edge-triggered D storage element, or a level-sensitive D storage element. In the two storage modes, input bit 0 carries data and input bit 1 acts as the cell clock. The clock polarity, the output polarity and the power-up stored value are all set by the same configuration word.

The whole cell runs on one fast system clock. Both signal inputs pass through a synchronizer. Cell-clock edges and levels are found by examining the synchronized samples, so the cell never uses its input as a real clock. The configuration word is written through a one-cycle strobe and is kept in a register. The output is registered.

Top module: `cfg_logic_cell`

## Requirements
- R1: While `rst` is high at a rising `clk` edge, the cell clears itself: the configuration becomes all zeros (table mode, empty table), the stored value becomes 0 and `cell_out` becomes 0 after that edge.
- R2: A rising `clk` edge with `cfg_we` high loads `cfg_data` into the configuration register. The field layout is: [8:7] mode, [6:3] truth table, [2] clock inversion, [1] output inversion, [0] initial value. Mode code 00 selects table mode, 01 edge storage and 10 level storage.
- R3: In table mode, `cell_out` equals truth-table bit number {in1,in0}, taken from the synchronized inputs, SYNC_STAGES+1 system clocks after the inputs change. Table 1000 therefore gives AND and table 0110 gives XOR.
- R4: Mode code 11 is reserved and behaves exactly like table mode.
- R5: In edge mode with clock inversion 0, the stored value takes the data input on a rising edge of in1 and holds at all other times.
- R6: In edge mode with clock inversion 1, the stored value takes the data input on a falling edge of in1 and holds at all other times.
- R7: In level mode with clock inversion 0, the stored value follows the data input while in1 is low. While in1 is high it holds, and changes on the data input have no effect.
- R8: In level mode with clock inversion 1, the stored value follows the data input while in1 is high. While in1 is low it holds and ignores the data input.
- R9: In both storage modes, `cell_out` is the stored value, or its complement when output inversion is 1. Output inversion acts after storage and never changes the stored value.
- R10: Every configuration write reloads the stored value from the initial-value bit of the written word. With no cell-clock activity, a storage mode then shows that value (after output inversion) at `cell_out`. In table mode the stored value is not updated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples inputs and clocks all registers |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_data | input | 9 | Configuration word (layout in R2) |
| cell_in | input | 2 | Cell inputs; bit 0 data/in0, bit 1 cell clock/in1 |
| cell_out | output | 1 | Registered cell output |

## Verification
The bench builds the cell with its default two-stage synchronizer. With that setting, an input change reaches `cell_out` three system clocks later, which sets the settling window the scoreboard waits before each comparison. The data and cell-clock inputs are often changed in the same cycle, so the cases where a data change and a capture or close event arrive together are covered. All four storage mode and polarity combinations are driven on top of a reference model kept in the bench. Configuration writes are made while the cell clock sits at either level, which reaches both the plain reload from the initial value and the case where a level-mode cell opens at once after the write.

// File: rtl/lcell_pkg.sv
package lcell_pkg;

  typedef enum logic [1:0] {
    MODE_LUT   = 2'b00,
    MODE_FLOP  = 2'b01,
    MODE_LATCH = 2'b10,
    MODE_RSVD  = 2'b11
  } cell_mode_e;

  typedef struct packed {
    cell_mode_e mode;
    logic [3:0] table_bits;
    logic       clk_inv;
    logic       out_inv;
    logic       init_val;
  } cell_cfg_t;

  localparam int CFG_W = $bits(cell_cfg_t);

endpackage

// File: rtl/lcell_cfg_reg.sv
module lcell_cfg_reg
  import lcell_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output cell_cfg_t        cfg_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else if (we) begin
      cfg_q <= cell_cfg_t'(wdata);
    end
  end

endmodule

// File: rtl/lcell_sync.sv
module lcell_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q,
  output logic [WIDTH-1:0] q_prev
);

  localparam int LAST = STAGES - 1;

  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= d;
  end

  generate
    for (genvar k = 1; k < STAGES; k++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stg[k] <= '0;
        else     stg[k] <= stg[k-1];
      end
    end
  endgenerate

  assign q = stg[LAST];

  always_ff @(posedge clk) begin
    if (rst) q_prev <= '0;
    else     q_prev <= q;
  end

endmodule

// File: rtl/lcell_store.sv
module lcell_store
  import lcell_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      load,
  input  logic      load_val,
  input  cell_cfg_t cfg,
  input  logic      d_s,
  input  logic      c_s,
  input  logic      c_prev,
  output logic      state_q
);

  logic edge_hit;
  logic open_lvl;

  // active edge: rising when not inverted, falling when inverted
  assign edge_hit = cfg.clk_inv ? (c_prev & ~c_s) : (~c_prev & c_s);
  // transparent level: low when not inverted, high when inverted
  assign open_lvl = (c_s == cfg.clk_inv);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= 1'b0;
    end else if (load) begin
      state_q <= load_val;
    end else begin
      case (cfg.mode)
        MODE_FLOP:  if (edge_hit) state_q <= d_s;
        MODE_LATCH: if (open_lvl) state_q <= d_s;
        default:    state_q <= state_q;
      endcase
    end
  end

endmodule

// File: rtl/lcell_outsel.sv
module lcell_outsel
  import lcell_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  cell_cfg_t  cfg,
  input  logic [1:0] in_s,
  input  logic       state_q,
  output logic       out_q
);

  logic nxt;

  always_comb begin
    case (cfg.mode)
      MODE_FLOP, MODE_LATCH: nxt = state_q ^ cfg.out_inv;
      default:               nxt = cfg.table_bits[in_s];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) out_q <= 1'b0;
    else     out_q <= nxt;
  end

endmodule

// File: rtl/cfg_logic_cell.sv
module cfg_logic_cell
  import lcell_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_data,
  input  logic [1:0]       cell_in,
  output logic             cell_out
);

  localparam int IN_W = 2;

  cell_cfg_t       cfg_q;
  logic [IN_W-1:0] sync_q;
  logic [IN_W-1:0] sync_prev;
  logic            state_q;

  lcell_cfg_reg i_cfg (
    .clk   (clk),
    .rst   (rst),
    .we    (cfg_we),
    .wdata (cfg_data),
    .cfg_q (cfg_q)
  );

  lcell_sync #(.WIDTH(IN_W), .STAGES(SYNC_STAGES)) i_sync (
    .clk    (clk),
    .rst    (rst),
    .d      (cell_in),
    .q      (sync_q),
    .q_prev (sync_prev)
  );

  lcell_store i_store (
    .clk      (clk),
    .rst      (rst),
    .load     (cfg_we),
    .load_val (cfg_data[0]),
    .cfg      (cfg_q),
    .d_s      (sync_q[0]),
    .c_s      (sync_q[1]),
    .c_prev   (sync_prev[1]),
    .state_q  (state_q)
  );

  lcell_outsel i_out (
    .clk     (clk),
    .rst     (rst),
    .cfg     (cfg_q),
    .in_s    (sync_q),
    .state_q (state_q),
    .out_q   (cell_out)
  );

endmodule

// File: rtl/lcell_chk.sv
module lcell_chk
  import lcell_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             cfg_we,
  input logic [CFG_W-1:0] cfg_data,
  input logic             cell_out,
  input cell_cfg_t        cfg_q,
  input logic [1:0]       sync_q,
  input logic [1:0]       sync_prev,
  input logic             state_q
);

  logic armed = 1'b0;
  always_ff @(posedge clk) if (rst) armed <= 1'b1;

  logic lut_like;
  logic seq_mode;
  assign lut_like = (cfg_q.mode == MODE_LUT) || (cfg_q.mode == MODE_RSVD);
  assign seq_mode = !lut_like;

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (cell_out == 1'b0 && state_q == 1'b0 && cfg_q == '0));

  assert_cfg_capture_R2: assert property (@(posedge clk) disable iff (rst)
    (armed && cfg_we) |=> (cfg_q == $past(cfg_data)));

  assert_table_out_R3: assert property (@(posedge clk) disable iff (rst)
    (armed && !cfg_we && lut_like) |=> (cell_out == $past(cfg_q.table_bits[sync_q])));

  assert_edge_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (armed && !cfg_we && cfg_q.mode == MODE_FLOP && sync_prev[1] == sync_q[1])
      |=> $stable(state_q));

  assert_level_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (armed && !cfg_we && cfg_q.mode == MODE_LATCH && sync_q[1] != cfg_q.clk_inv)
      |=> $stable(state_q));

  assert_out_polarity_R9: assert property (@(posedge clk) disable iff (rst)
    (armed && !cfg_we && seq_mode) |=> (cell_out == ($past(state_q) ^ $past(cfg_q.out_inv))));

  assert_init_reload_R10: assert property (@(posedge clk) disable iff (rst)
    (armed && cfg_we) |=> (state_q == $past(cfg_data[0])));

  assert_table_no_update_R10: assert property (@(posedge clk) disable iff (rst)
    (armed && !cfg_we && lut_like) |=> $stable(state_q));

endmodule

bind cfg_logic_cell lcell_chk i_chk (
  .clk       (clk),
  .rst       (rst),
  .cfg_we    (cfg_we),
  .cfg_data  (cfg_data),
  .cell_out  (cell_out),
  .cfg_q     (cfg_q),
  .sync_q    (sync_q),
  .sync_prev (sync_prev),
  .state_q   (state_q)
);

// File: tb/test_cfg_logic_cell.sv
`timescale 1ns/1ps
module test_cfg_logic_cell;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [8:0] cfg_data = '0;
  logic [1:0] cell_in = '0;
  logic       cell_out;

  always #4 clk = ~clk;

  cfg_logic_cell i_cfg_logic_cell (
    .clk      (clk),
    .rst      (rst),
    .cfg_we   (cfg_we),
    .cfg_data (cfg_data),
    .cell_in  (cell_in),
    .cell_out (cell_out)
  );

  typedef struct {
    logic  exp;
    string tag;
  } sb_item_t;

  sb_item_t sb[$];
  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  // bench reference state
  logic [1:0] m_mode = 2'b00;
  logic [3:0] m_tt = 4'b0000;
  logic m_ci = 0, m_oi = 0, m_q = 0;
  logic cur_d = 0, cur_c = 0;

  function automatic logic model_out();
    if (m_mode == 2'b01 || m_mode == 2'b10) return m_q ^ m_oi;
    return m_tt[{cur_c, cur_d}];
  endfunction

  task automatic push(input logic e, input string tag);
    sb_item_t it;
    it.exp = e;
    it.tag = tag;
    sb.push_back(it);
  endtask

  always @(negedge clk) begin
    if (sb.size() > 0) begin
      sb_item_t it;
      it = sb.pop_front();
      n_vec++;
      if (cell_out !== it.exp) begin
        n_bad++;
        $display("FAIL %s: cell_out=%b expected %b", it.tag, cell_out, it.exp);
      end
    end
  end

  task automatic drive(input logic d, input logic c, input string tag);
    logic old_c;
    @(negedge clk);
    old_c = cur_c;
    cur_d = d;
    cur_c = c;
    cell_in = {c, d};
    if (m_mode == 2'b01) begin
      if (m_ci ? (old_c && !c) : (!old_c && c)) m_q = d;
    end else if (m_mode == 2'b10) begin
      if (c == m_ci) m_q = d;
    end
    repeat (6) @(posedge clk);
    push(model_out(), tag);
  endtask

  task automatic write_cfg(input logic [1:0] mode, input logic [3:0] tt,
                           input logic ci, input logic oi, input logic init,
                           input string tag);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_data = {mode, tt, ci, oi, init};
    @(negedge clk);
    cfg_we = 1'b0;
    m_mode = mode;
    m_tt = tt;
    m_ci = ci;
    m_oi = oi;
    m_q = init;
    if (mode == 2'b10 && cur_c == ci) m_q = cur_d;
    repeat (4) @(posedge clk);
    push(model_out(), tag);
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(posedge clk);
    push(1'b0, tag);
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_mode = 2'b00;
    m_tt = 4'b0000;
    m_ci = 0;
    m_oi = 0;
    m_q = 0;
  endtask

  initial begin
    do_reset("R1 reset clear");
    drive(1, 1, "R1 empty table after reset");

    // R2 + R3: AND table (bit 3 only)
    write_cfg(2'b00, 4'b1000, 0, 0, 0, "R2 load AND table");
    drive(0, 0, "R3 AND 00");
    drive(1, 0, "R3 AND in0 only");
    drive(0, 1, "R3 AND in1 only");
    drive(1, 1, "R3 AND 11");
    // XOR table
    write_cfg(2'b00, 4'b0110, 0, 0, 0, "R3 XOR load");
    drive(1, 0, "R3 XOR 01");
    drive(0, 0, "R3 XOR 00");
    drive(0, 1, "R3 XOR 10");
    // NAND table, index ordering check
    write_cfg(2'b00, 4'b0111, 0, 0, 1, "R3 NAND load");
    drive(1, 1, "R3 NAND 11");
    drive(1, 0, "R3 NAND 01");
    // R4 reserved code behaves as table
    write_cfg(2'b11, 4'b0100, 0, 0, 1, "R4 reserved load");
    drive(0, 1, "R4 reserved index 2");
    drive(1, 0, "R4 reserved index 1");

    // R5 edge mode, rising
    drive(1, 0, "R4 setup level");
    write_cfg(2'b01, 4'b0000, 0, 0, 0, "R10 init 0 edge mode");
    drive(1, 0, "R5 no edge hold");
    drive(1, 1, "R5 rising capture 1");
    drive(0, 1, "R5 data change no edge");
    drive(0, 0, "R5 falling ignored");
    drive(0, 1, "R5 rising capture 0");

    // R6 edge mode, falling
    write_cfg(2'b01, 4'b0000, 1, 0, 1, "R10 init 1 edge mode");
    drive(0, 1, "R6 no edge hold");
    drive(0, 0, "R6 falling capture 0");
    drive(1, 0, "R6 data change no edge");
    drive(1, 1, "R6 rising ignored");
    drive(1, 0, "R6 falling capture 1");

    // R7 level mode, open while low
    write_cfg(2'b10, 4'b0000, 0, 0, 0, "R7 opens at write");
    drive(0, 0, "R7 follows low");
    drive(1, 1, "R7 close with data change");
    drive(0, 1, "R7 data ignored closed");
    drive(1, 1, "R7 data ignored closed again");
    drive(1, 0, "R7 reopens");

    // R8 level mode, open while high
    write_cfg(2'b10, 4'b0000, 1, 0, 0, "R8 closed at write");
    drive(0, 0, "R8 data ignored low");
    drive(1, 0, "R8 data ignored low again");
    drive(1, 1, "R8 follows high");
    drive(0, 1, "R8 follows high 0");
    drive(1, 0, "R8 hold after close");

    // R9 output inversion
    write_cfg(2'b01, 4'b0000, 0, 1, 0, "R9 inverted init");
    drive(1, 0, "R9 hold inverted");
    drive(1, 1, "R9 stored 1 shown 0");
    drive(0, 0, "R9 hold inverted after fall");

    // R10 table mode leaves state; switching back reloads init
    write_cfg(2'b00, 4'b1111, 0, 0, 0, "R10 table all ones");
    drive(0, 1, "R10 table drive");
    write_cfg(2'b01, 4'b0000, 0, 0, 1, "R10 back to edge reload");

    // R1 mid-run reset
    do_reset("R1 reset mid run");
    drive(1, 1, "R1 table cleared");

    repeat (4) @(posedge clk);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule